// File: doc/BRIEF.md
# Cross-Domain Command Dispatcher with Dual Acknowledge

This block takes control commands written by a host on its bus clock and hands each one to the two halves of a serial channel: a transmit section on its own clock and a receive section on another. Either section clock may be gapped or stopped for long stretches. A section whose clock is idle keeps its state unchanged and responds only once its clock runs again.

Every accepted command goes to both sections, whichever one it actually affects. Each section reports back that it has executed the command. A readable busy bit stays set from the accepted write until both reports have arrived in the host domain. While busy is set, the block refuses further writes and records the refusal in a sticky flag, which a status read clears. The request and the acknowledgements cross the clock boundaries as level toggles through multi-flop synchronizers. The command word itself is held still in the host domain while the request is in flight. Each section contains a small stub that turns its own reset bit of the command into a one-cycle reset pulse.

Top module: `cmd_xdom_dispatch`

## Requirements
- R1: While `arst_n` is low and right after it rises, `host_busy`, `host_dropped`, `tx_exec`, `rx_exec`, `tx_reset` and `rx_reset` are all 0.
- R2: A `host_wr` sampled while busy is clear is accepted, and `host_busy` reads 1 from that host clock edge on. A second write in the very next host cycle is therefore refused.
- R3: Every accepted command raises `tx_exec` for exactly one transmit clock cycle and `rx_exec` for exactly one receive clock cycle. During that cycle `tx_cmd` and `rx_cmd` carry the full written word.
- R4: Bit 0 of the command word is the transmitter reset and bit 1 is the receiver reset. `tx_reset` is high only in a `tx_exec` cycle whose word has bit 0 set. `rx_reset` is high only in an `rx_exec` cycle whose word has bit 1 set.
- R5: `host_busy` falls only after both sections have executed the accepted command, even when the command's reset bits touch only one section.
- R6: A write refused while busy causes no execution in either section and does not alter the word delivered for the command in flight.
- R7: A refused write sets `host_dropped`. The flag stays set until a cycle with `host_rd_stat` high and no new refusal. When a refusal and a read fall in the same cycle, the flag stays set.
- R8: If one section's clock is held constant, the other section still executes and `host_busy` stays set indefinitely. Once the clock resumes, the stalled section executes the same command and busy clears.
- R9: A section executes on its own clock edge number SYNC_STAGES+1 after the request toggles. `host_busy` falls on host edge number SYNC_STAGES+1 after the later acknowledge toggle, which at the default settings is within 25 ns of the later execute strobe being seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host bus clock |
| tclk | input | 1 | Transmit section clock, may be gapped |
| rclk | input | 1 | Receive section clock, may be gapped |
| arst_n | input | 1 | Global asynchronous reset, active low |
| host_wr | input | 1 | Command register write strobe |
| host_wdata | input | CMD_W | Command word |
| host_rd_stat | input | 1 | Status read strobe, clears the drop flag |
| host_busy | output | 1 | Command executing |
| host_dropped | output | 1 | Sticky: a write was refused |
| tx_exec | output | 1 | One-cycle execute strobe in the transmit domain |
| tx_cmd | output | CMD_W | Command word seen by the transmit section |
| tx_reset | output | 1 | Transmitter reset pulse |
| rx_exec | output | 1 | One-cycle execute strobe in the receive domain |
| rx_cmd | output | CMD_W | Command word seen by the receive section |
| rx_reset | output | 1 | Receiver reset pulse |

## Verification
Busy is due one host cycle after an accepted write. The bench reads it at the next falling host edge, and at the same point it reads the drop flag after a refused or read cycle. Execute strobes come SYNC_STAGES+1 section clock edges after the write, so their cycle depends on the phase between clocks. A scoreboard therefore pops the expected word at each falling section edge where a strobe is seen, instead of at a fixed time. The fall of busy is polled on every falling host edge. It is checked against the time the later strobe was seen, and against the scoreboard being empty at that moment, so a premature clear and a late clear are both caught.

// File: rtl/cmd_xdom_pkg.sv
package cmd_xdom_pkg;
   localparam int unsigned NUM_SEC    = 2;
   localparam int unsigned SEC_TX     = 0;
   localparam int unsigned SEC_RX     = 1;
   localparam int unsigned TX_RST_BIT = 0;
   localparam int unsigned RX_RST_BIT = 1;

   function automatic int unsigned sec_rst_bit(input int unsigned sec);
      return (sec == SEC_TX) ? TX_RST_BIT : RX_RST_BIT;
   endfunction
endpackage

// File: rtl/cmd_sync.sv
module cmd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d_async,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("cmd_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain[0] <= 1'b0;
      else         chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) chain[s] <= 1'b0;
         else         chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cmd_section.sv
module cmd_section #(
   parameter int unsigned CMD_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_BIT     = 0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             req_tgl,
   input  logic [CMD_W-1:0] cmd_in,
   output logic             ack_tgl,
   output logic             exec,
   output logic [CMD_W-1:0] cmd_out,
   output logic             rst_out
);
   logic req_s;
   logic new_req;

   initial begin
      assert (RST_BIT < CMD_W) else $error("cmd_section: RST_BIT outside command word");
   end

   cmd_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk     (clk),
      .arst_n  (arst_n),
      .d_async (req_tgl),
      .q       (req_s)
   );

   assign new_req = req_s ^ ack_tgl;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         ack_tgl <= 1'b0;
         exec    <= 1'b0;
         cmd_out <= '0;
         rst_out <= 1'b0;
      end else begin
         ack_tgl <= ack_tgl ^ new_req;
         exec    <= new_req;
         rst_out <= new_req & cmd_in[RST_BIT];
         if (new_req) cmd_out <= cmd_in;
      end
   end

   assert_rst_own_bit_R4: assert property (@(posedge clk) disable iff (!arst_n)
      rst_out |-> (exec && cmd_out[RST_BIT]));

   assert_exec_single_R3: assert property (@(posedge clk) disable iff (!arst_n)
      exec |=> !exec);
endmodule

// File: rtl/cmd_host_ctrl.sv
module cmd_host_ctrl #(
   parameter int unsigned CMD_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             hclk,
   input  logic             arst_n,
   input  logic             wr,
   input  logic [CMD_W-1:0] wdata,
   input  logic             rd_stat,
   input  logic             tx_ack_tgl,
   input  logic             rx_ack_tgl,
   output logic             busy,
   output logic             dropped,
   output logic             req_tgl,
   output logic [CMD_W-1:0] cmd_q
);
   logic tx_ack_s, rx_ack_s;
   logic accept, refuse, both_done;

   cmd_sync #(.STAGES(SYNC_STAGES)) u_tx_ack_sync (
      .clk (hclk), .arst_n (arst_n), .d_async (tx_ack_tgl), .q (tx_ack_s)
   );
   cmd_sync #(.STAGES(SYNC_STAGES)) u_rx_ack_sync (
      .clk (hclk), .arst_n (arst_n), .d_async (rx_ack_tgl), .q (rx_ack_s)
   );

   assign accept    = wr & ~busy;
   assign refuse    = wr & busy;
   assign both_done = (tx_ack_s == req_tgl) && (rx_ack_s == req_tgl);

   always_ff @(posedge hclk or negedge arst_n) begin
      if (!arst_n) begin
         busy    <= 1'b0;
         dropped <= 1'b0;
         req_tgl <= 1'b0;
         cmd_q   <= '0;
      end else begin
         busy    <= accept | (busy & ~both_done);
         dropped <= refuse | (dropped & ~rd_stat);
         if (accept) begin
            req_tgl <= ~req_tgl;
            cmd_q   <= wdata;
         end
      end
   end

   assert_busy_on_accept_R2: assert property (@(posedge hclk) disable iff (!arst_n)
      (wr && !busy) |=> busy);

   assert_drop_sets_R7: assert property (@(posedge hclk) disable iff (!arst_n)
      (wr && busy) |=> dropped);

   assert_word_held_R6: assert property (@(posedge hclk) disable iff (!arst_n)
      busy |=> $stable(cmd_q));

   assert_busy_waits_R5: assert property (@(posedge hclk) disable iff (!arst_n)
      (busy && (tx_ack_s != req_tgl)) |=> busy);
endmodule

// File: rtl/cmd_xdom_dispatch.sv
module cmd_xdom_dispatch
   import cmd_xdom_pkg::*;
#(
   parameter int unsigned CMD_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             hclk,
   input  logic             tclk,
   input  logic             rclk,
   input  logic             arst_n,
   input  logic             host_wr,
   input  logic [CMD_W-1:0] host_wdata,
   input  logic             host_rd_stat,
   output logic             host_busy,
   output logic             host_dropped,
   output logic             tx_exec,
   output logic [CMD_W-1:0] tx_cmd,
   output logic             tx_reset,
   output logic             rx_exec,
   output logic [CMD_W-1:0] rx_cmd,
   output logic             rx_reset
);
   logic               req_tgl;
   logic [CMD_W-1:0]   cmd_q;
   logic [NUM_SEC-1:0] sec_clk, sec_ack, sec_exec, sec_rst;
   logic [CMD_W-1:0]   sec_cmd [NUM_SEC];

   initial begin
      assert (CMD_W >= 2) else $error("cmd_xdom_dispatch: CMD_W must hold both reset bits");
      assert (SYNC_STAGES >= 2) else $error("cmd_xdom_dispatch: SYNC_STAGES below 2");
   end

   assign sec_clk[SEC_TX] = tclk;
   assign sec_clk[SEC_RX] = rclk;

   cmd_host_ctrl #(.CMD_W(CMD_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
      .hclk       (hclk),
      .arst_n     (arst_n),
      .wr         (host_wr),
      .wdata      (host_wdata),
      .rd_stat    (host_rd_stat),
      .tx_ack_tgl (sec_ack[SEC_TX]),
      .rx_ack_tgl (sec_ack[SEC_RX]),
      .busy       (host_busy),
      .dropped    (host_dropped),
      .req_tgl    (req_tgl),
      .cmd_q      (cmd_q)
   );

   for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
      cmd_section #(
         .CMD_W       (CMD_W),
         .SYNC_STAGES (SYNC_STAGES),
         .RST_BIT     (sec_rst_bit(g))
      ) u_sec (
         .clk     (sec_clk[g]),
         .arst_n  (arst_n),
         .req_tgl (req_tgl),
         .cmd_in  (cmd_q),
         .ack_tgl (sec_ack[g]),
         .exec    (sec_exec[g]),
         .cmd_out (sec_cmd[g]),
         .rst_out (sec_rst[g])
      );
   end

   assign tx_exec  = sec_exec[SEC_TX];
   assign tx_cmd   = sec_cmd[SEC_TX];
   assign tx_reset = sec_rst[SEC_TX];
   assign rx_exec  = sec_exec[SEC_RX];
   assign rx_cmd   = sec_cmd[SEC_RX];
   assign rx_reset = sec_rst[SEC_RX];
endmodule

// File: tb/sim_cmd_xdom_dispatch.sv
`timescale 1ns/1ps
module sim_cmd_xdom_dispatch;
   localparam int unsigned CMD_W = 8;

   logic hclk = 0, tclk = 0, rclk = 0, rclk_run = 1;
   logic arst_n = 0, host_wr = 0, host_rd_stat = 0;
   logic [CMD_W-1:0] host_wdata = '0;
   logic host_busy, host_dropped, tx_exec, tx_reset, rx_exec, rx_reset;
   logic [CMD_W-1:0] tx_cmd, rx_cmd;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [CMD_W-1:0] exp_tx[$], exp_rx[$];
   logic [CMD_W-1:0] etx, erx;
   realtime last_exec_t = 0;

   always #2.5 hclk = ~hclk;
   always #3.5 tclk = ~tclk;
   always begin #5.5; if (rclk_run) rclk = ~rclk; end

   cmd_xdom_dispatch #(.CMD_W(CMD_W), .SYNC_STAGES(2)) u0 (
      .hclk(hclk), .tclk(tclk), .rclk(rclk), .arst_n(arst_n),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rd_stat(host_rd_stat),
      .host_busy(host_busy), .host_dropped(host_dropped),
      .tx_exec(tx_exec), .tx_cmd(tx_cmd), .tx_reset(tx_reset),
      .rx_exec(rx_exec), .rx_cmd(rx_cmd), .rx_reset(rx_reset)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitors, sampling on falling section edges
   always @(negedge tclk) if (arst_n) begin
      if (tx_reset && !tx_exec) chk(0, "R4 tx_reset outside exec", 1, 0);
      if (tx_exec) begin
         if (exp_tx.size() == 0) chk(0, "R6 unexpected tx exec", tx_cmd, 0);
         else begin
            etx = exp_tx.pop_front();
            chk(tx_cmd == etx, "R3 tx word", tx_cmd, etx);
            chk(tx_reset == etx[0], "R4 tx_reset from bit 0", tx_reset, etx[0]);
         end
         last_exec_t = $realtime;
      end
   end

   always @(negedge rclk) if (arst_n) begin
      if (rx_reset && !rx_exec) chk(0, "R4 rx_reset outside exec", 1, 0);
      if (rx_exec) begin
         if (exp_rx.size() == 0) chk(0, "R6 unexpected rx exec", rx_cmd, 0);
         else begin
            erx = exp_rx.pop_front();
            chk(rx_cmd == erx, "R3 rx word", rx_cmd, erx);
            chk(rx_reset == erx[1], "R4 rx_reset from bit 1", rx_reset, erx[1]);
         end
         last_exec_t = $realtime;
      end
   end

   task automatic host_write(input logic [CMD_W-1:0] d);
      @(negedge hclk);
      host_wr = 1; host_wdata = d;
      exp_tx.push_back(d); exp_rx.push_back(d);
      @(negedge hclk);
      host_wr = 0;
      chk(host_busy == 1, "R2 busy after accepted write", host_busy, 1);
   endtask

   task automatic wait_idle();
      realtime t;
      int n = 0;
      while (host_busy && n < 200) begin @(negedge hclk); n++; end
      t = $realtime;
      chk(!host_busy, "R5 busy never cleared", host_busy, 0);
      chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R5 busy fell before both executed",
          exp_tx.size() + exp_rx.size(), 0);
      chk((t - last_exec_t) > 0 && (t - last_exec_t) <= 25.0, "R9 busy clear latency ns",
          int'(t - last_exec_t), 25);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge hclk);
      chk(host_busy == 0 && host_dropped == 0, "R1 host status in reset", {host_busy, host_dropped}, 0);
      chk(tx_exec == 0 && rx_exec == 0 && tx_reset == 0 && rx_reset == 0, "R1 section outputs in reset",
          {tx_exec, rx_exec, tx_reset, rx_reset}, 0);
      arst_n = 1;
      repeat (3) @(negedge hclk);
      chk(host_busy == 0 && host_dropped == 0, "R1 status after reset", {host_busy, host_dropped}, 0);

      // R2/R7: back-to-back write, second refused
      @(negedge hclk);
      host_wr = 1; host_wdata = 8'h01;
      exp_tx.push_back(8'h01); exp_rx.push_back(8'h01);
      @(negedge hclk);
      chk(host_busy == 1, "R2 busy after accepted write", host_busy, 1);
      host_wdata = 8'h02;
      @(negedge hclk);
      host_wr = 0;
      chk(host_dropped == 1, "R7 drop flag on refused write", host_dropped, 1);
      wait_idle();
      chk(host_dropped == 1, "R7 drop flag sticky", host_dropped, 1);
      @(negedge hclk); host_rd_stat = 1;
      @(negedge hclk); host_rd_stat = 0;
      chk(host_dropped == 0, "R7 drop flag cleared by read", host_dropped, 0);

      // R3/R4: several words, each touching different sections
      host_write(8'h02); wait_idle();
      host_write(8'h03); wait_idle();
      host_write(8'h00); wait_idle();
      host_write(8'hA5); wait_idle();
      host_write(8'h5A); wait_idle();

      // R8: receive clock held constant
      @(negedge rclk); rclk_run = 0;
      host_write(8'h03);
      repeat (200) @(negedge hclk);
      chk(host_busy == 1, "R8 busy held with stopped rx clock", host_busy, 1);
      chk(exp_tx.size() == 0, "R8 tx executed while rx stalled", exp_tx.size(), 0);
      chk(exp_rx.size() == 1, "R8 rx pending while stalled", exp_rx.size(), 1);
      // R6: refused write during stall changes nothing
      @(negedge hclk); host_wr = 1; host_wdata = 8'hFE;
      @(negedge hclk); host_wr = 0;
      chk(host_dropped == 1, "R7 drop flag during stall", host_dropped, 1);
      repeat (20) @(negedge hclk);
      chk(exp_tx.size() == 0, "R6 refused write not executed in tx", exp_tx.size(), 0);
      rclk_run = 1;
      wait_idle();

      // R7: refusal and read in the same cycle keep the flag set
      host_write(8'h10);
      @(negedge hclk); host_wr = 1; host_rd_stat = 1; host_wdata = 8'h20;
      @(negedge hclk); host_wr = 0; host_rd_stat = 0;
      chk(host_dropped == 1, "R7 refusal wins over read", host_dropped, 1);
      wait_idle();
      repeat (30) @(negedge hclk);
      chk(exp_tx.size() == 0 && exp_rx.size() == 0, "R6 no leftover executions",
          exp_tx.size() + exp_rx.size(), 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule